// File: doc/BRIEF.md
# Windowed Average-Frequency Meter

This block estimates the average rate of an already debounced pulse train. It runs a window timer of programmable length, counted in base-clock cycles, and within each window it watches for one chosen edge of the input. It notes how many base-clock cycles separate the first chosen edge from the last one, and how many edges followed the first. The ratio of those two numbers gives the average period, and the measurement does not depend on where the edges fall relative to the window boundaries.

When a window ends, both numbers are published together with a one-cycle valid strobe. The next window opens at once, with no idle cycle in between. A window in which fewer than two chosen edges were seen publishes zero for both numbers. Measurement can begin as soon as the block is enabled, or it can wait for a software trigger, a global trigger or a rising edge on the gate input. Dropping the enable stops measurement, and the last published results are kept.

Top module: `avg_freq_meter`

## Requirements
- R1: After reset, `interval_q` and `pulses_q` are zero and `result_vld` is low.
- R2: With `start_mode`=0, a high `enable` opens the first window in the cycle after it is sampled. With `start_mode`=1, no window opens until `sw_trig`, `glob_trig` or a rising edge of `gate_in` is sampled while `enable` is high. Until then, `result_vld` stays low and the results do not change.
- R3: A window lasts `win_len` base-clock cycles, and any value below 2 is treated as 2. Windows follow each other with no gap. `result_vld` is high for exactly one cycle, in the cycle right after the last cycle of each window.
- R4: `edge_fall`=0 selects rising edges of `sig_in` and `edge_fall`=1 selects falling edges. An edge is the change between the values sampled at two consecutive clock edges.
- R5: With two or more selected edges in a window, `interval_q` equals the number of base-clock cycles from the first selected edge to the last one.
- R6: With two or more selected edges in a window, `pulses_q` equals the number of selected edges minus one.
- R7: A window with zero or one selected edge publishes 0 in both `interval_q` and `pulses_q`.
- R8: An edge in the last cycle of a window counts toward that window. Edges that occur before the first window opens are ignored.
- R9: While `enable` is low, no window runs and `result_vld` stays low. When `enable` falls in the middle of a window, that window is abandoned and the last published results are held.
- R10: `interval_q` and `pulses_q` change only together with a high `result_vld`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows measurement; low stops it |
| start_mode | input | 1 | 0: start on enable, 1: wait for a trigger |
| sw_trig | input | 1 | Software start pulse |
| glob_trig | input | 1 | Global start pulse |
| gate_in | input | 1 | Gate line; a rising edge is a start trigger |
| sig_in | input | 1 | Debounced pulse train to measure |
| edge_fall | input | 1 | 0: measure rising edges, 1: measure falling edges |
| win_len | input | WIN_W | Window length in base-clock cycles |
| interval_q | output | CNT_W | Cycles from the first to the last selected edge |
| pulses_q | output | CNT_W | Selected edges after the first one |
| result_vld | output | 1 | One-cycle strobe when a window's results are published |

## Verification
The main function is tried with single-cycle pulse trains over a range of periods and phases, for both edge polarities, across three back-to-back windows each. Short periods give many edges per window and exercise the interval and the count. Periods longer than the window give windows with zero or one edge, which separates the zero-forcing rule from ordinary counting. Phases that place an edge in the last cycle of a window, or a falling edge in the first cycle of the next one, show which window each boundary edge is charged to. Separate runs cover each trigger source, a trigger mode left waiting with no trigger, a window length below the minimum, and dropping the enable in mid-window.

// File: rtl/afm_pkg.sv
package afm_pkg;

   typedef enum logic {
      START_ON_ENABLE  = 1'b0,
      START_ON_TRIGGER = 1'b1
   } start_mode_e;

   localparam int unsigned MIN_WIN = 2;

endpackage

// File: rtl/afm_edge_det.sv
module afm_edge_det #(
   parameter bit GATE_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_in,
   input  logic edge_fall,
   input  logic gate_in,
   output logic sel_edge,
   output logic gate_edge
);

   logic prev_sig;
   logic prev_gate;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_sig  <= 1'b0;
         prev_gate <= 1'b0;
      end else begin
         prev_sig  <= sig_in;
         prev_gate <= gate_in;
      end
   end

   always_comb begin
      if (edge_fall) sel_edge = prev_sig & ~sig_in;
      else           sel_edge = ~prev_sig & sig_in;
   end

   generate
      if (GATE_RISE) begin : g_gate_rise
         assign gate_edge = gate_in & ~prev_gate;
      end else begin : g_gate_fall
         assign gate_edge = ~gate_in & prev_gate;
      end
   endgenerate

endmodule

// File: rtl/afm_window.sv
module afm_window
   import afm_pkg::*;
#(
   parameter int unsigned WIN_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic [WIN_W-1:0] win_len,
   output logic             running,
   output logic             expire
);

   localparam logic [WIN_W-1:0] MIN_LEN = WIN_W'(MIN_WIN);
   localparam logic [WIN_W-1:0] ONE     = WIN_W'(1);

   logic [WIN_W-1:0] left_q;
   logic [WIN_W-1:0] eff_len;

   assign eff_len = (win_len < MIN_LEN) ? MIN_LEN : win_len;
   assign expire  = running & ~stop & (left_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         left_q  <= '0;
      end else if (stop) begin
         running <= 1'b0;
         left_q  <= '0;
      end else if (start) begin
         running <= 1'b1;
         left_q  <= eff_len;
      end else if (running) begin
         if (expire) left_q <= eff_len;
         else        left_q <= left_q - ONE;
      end
   end

endmodule

// File: rtl/afm_accum.sv
module afm_accum #(
   parameter int unsigned CNT_W = 32,
   parameter bit          SAT   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             running,
   input  logic             clear,
   input  logic             sel_edge,
   input  logic             expire,
   output logic [CNT_W-1:0] interval_q,
   output logic [CNT_W-1:0] pulses_q,
   output logic             result_vld
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             seen_q;
   logic [CNT_W-1:0] tic_q;
   logic [CNT_W-1:0] last_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] tic_inc;
   logic             edge_ok;
   logic             first_edge;
   logic             later_edge;
   logic [CNT_W-1:0] last_nx;
   logic [CNT_W-1:0] cnt_nx;
   logic             enough;

   generate
      if (SAT) begin : g_sat
         assign tic_inc = (&tic_q) ? tic_q : tic_q + ONE;
      end else begin : g_wrap
         assign tic_inc = tic_q + ONE;
      end
   endgenerate

   always_comb begin
      edge_ok    = running & sel_edge;
      first_edge = edge_ok & ~seen_q;
      later_edge = edge_ok & seen_q;
      last_nx    = later_edge ? tic_q : last_q;
      cnt_nx     = later_edge ? cnt_q + ONE : cnt_q;
      enough     = seen_q & (cnt_nx != '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q     <= 1'b0;
         tic_q      <= '0;
         last_q     <= '0;
         cnt_q      <= '0;
         interval_q <= '0;
         pulses_q   <= '0;
         result_vld <= 1'b0;
      end else begin
         result_vld <= expire;
         if (clear) begin
            seen_q <= 1'b0;
            tic_q  <= '0;
            last_q <= '0;
            cnt_q  <= '0;
         end else if (running) begin
            if (expire) begin
               interval_q <= enough ? last_nx : '0;
               pulses_q   <= enough ? cnt_nx : '0;
               seen_q     <= 1'b0;
               tic_q      <= '0;
               last_q     <= '0;
               cnt_q      <= '0;
            end else begin
               if (first_edge) begin
                  seen_q <= 1'b1;
                  tic_q  <= ONE;
               end else begin
                  tic_q  <= tic_inc;
               end
               last_q <= last_nx;
               cnt_q  <= cnt_nx;
            end
         end
      end
   end

endmodule

// File: rtl/avg_freq_meter.sv
module avg_freq_meter
   import afm_pkg::*;
#(
   parameter int unsigned WIN_W     = 32,
   parameter int unsigned CNT_W     = 32,
   parameter bit          SAT_TIC   = 1'b1,
   parameter bit          GATE_RISE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             start_mode,
   input  logic             sw_trig,
   input  logic             glob_trig,
   input  logic             gate_in,
   input  logic             sig_in,
   input  logic             edge_fall,
   input  logic [WIN_W-1:0] win_len,
   output logic [CNT_W-1:0] interval_q,
   output logic [CNT_W-1:0] pulses_q,
   output logic             result_vld
);

   generate
      if (WIN_W < 2) begin : g_bad_win
         $error("avg_freq_meter: WIN_W must be at least 2");
      end
      if (CNT_W < WIN_W) begin : g_bad_cnt
         $error("avg_freq_meter: CNT_W must not be narrower than WIN_W");
      end
   endgenerate

   logic        sel_edge;
   logic        gate_edge;
   logic        running;
   logic        expire;
   logic        trig_any;
   logic        start;
   logic        stop;
   start_mode_e mode;

   assign mode     = start_mode_e'(start_mode);
   assign trig_any = sw_trig | glob_trig | gate_edge;
   assign stop     = ~enable;
   assign start    = enable & ~running &
                     ((mode == START_ON_ENABLE) | trig_any);

   afm_edge_det #(
      .GATE_RISE (GATE_RISE)
   ) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .sig_in    (sig_in),
      .edge_fall (edge_fall),
      .gate_in   (gate_in),
      .sel_edge  (sel_edge),
      .gate_edge (gate_edge)
   );

   afm_window #(
      .WIN_W (WIN_W)
   ) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .stop    (stop),
      .win_len (win_len),
      .running (running),
      .expire  (expire)
   );

   afm_accum #(
      .CNT_W (CNT_W),
      .SAT   (SAT_TIC)
   ) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .running    (running),
      .clear      (stop),
      .sel_edge   (sel_edge),
      .expire     (expire),
      .interval_q (interval_q),
      .pulses_q   (pulses_q),
      .result_vld (result_vld)
   );

endmodule

// File: rtl/afm_checker.sv
module afm_checker #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic [CNT_W-1:0] interval_q,
   input logic [CNT_W-1:0] pulses_q,
   input logic             result_vld
);

   // R3
   vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result_vld |=> !result_vld);

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !result_vld);

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !result_vld |-> ($stable(interval_q) && $stable(pulses_q)));

   // R7
   zero_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (result_vld && pulses_q == '0) |-> (interval_q == '0));

   // R5
   span_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result_vld |-> (interval_q >= pulses_q));

endmodule

bind avg_freq_meter afm_checker #(
   .CNT_W (CNT_W)
) u_afm_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .interval_q (interval_q),
   .pulses_q   (pulses_q),
   .result_vld (result_vld)
);

// File: tb/avg_freq_meter_bench.sv
module avg_freq_meter_bench;

   localparam int WIN_W = 8;
   localparam int CNT_W = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             enable = 1'b0;
   logic             start_mode = 1'b0;
   logic             sw_trig = 1'b0;
   logic             glob_trig = 1'b0;
   logic             gate_in = 1'b0;
   logic             sig_in = 1'b0;
   logic             edge_fall = 1'b0;
   logic [WIN_W-1:0] win_len = 8'd16;
   logic [CNT_W-1:0] interval_q;
   logic [CNT_W-1:0] pulses_q;
   logic             result_vld;

   int total = 0;
   int bad = 0;
   int last_iv = 0;
   int last_pc = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   avg_freq_meter #(
      .WIN_W (WIN_W),
      .CNT_W (CNT_W)
   ) u_avg_freq_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .start_mode (start_mode),
      .sw_trig    (sw_trig),
      .glob_trig  (glob_trig),
      .gate_in    (gate_in),
      .sig_in     (sig_in),
      .edge_fall  (edge_fall),
      .win_len    (win_len),
      .interval_q (interval_q),
      .pulses_q   (pulses_q),
      .result_vld (result_vld)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit sig_at(input int g, input int per, input int ph);
      if (g < ph) return 1'b0;
      return ((g - ph) % per) == 0;
   endfunction

   function automatic bit edge_at(input int g, input int per, input int ph, input bit fall);
      bit a, b;
      a = sig_at(g - 1, per, ph);
      b = sig_at(g, per, ph);
      return fall ? (a & ~b) : (~a & b);
   endfunction

   task automatic expect_win(input int j, input int len, input int per, input int ph,
                             input bit fall, output int iv, output int pc);
      int first, last, n;
      first = -1; last = -1; n = 0;
      for (int g = j * len; g < (j + 1) * len; g++) begin
         if (edge_at(g, per, ph, fall)) begin
            if (first < 0) first = g;
            last = g;
            n++;
         end
      end
      if (n < 2) begin iv = 0; pc = 0; end
      else begin iv = last - first; pc = n - 1; end
   endtask

   task automatic go_idle();
      @(negedge clk);
      enable = 1'b0; sig_in = 1'b0; gate_in = 1'b0; sw_trig = 1'b0; glob_trig = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // kind: 0 enable start, 1 software, 2 global, 3 gate rising edge
   task automatic run_cfg(input int len_in, input int len, input int per, input int ph,
                          input bit fall, input int nwin, input int kind);
      int iv, pc, stray;
      stray = 0;
      go_idle();
      @(negedge clk);
      edge_fall  = fall;
      win_len    = WIN_W'(len_in);
      start_mode = (kind != 0);
      enable     = 1'b1;
      sw_trig    = (kind == 1);
      glob_trig  = (kind == 2);
      gate_in    = (kind == 3);
      sig_in     = 1'b0;
      for (int g = 0; g <= nwin * len; g++) begin
         @(negedge clk);
         sw_trig = 1'b0; glob_trig = 1'b0; gate_in = 1'b0;
         if (g > 0 && (g % len) == 0) begin
            expect_win(g / len - 1, len, per, ph, fall, iv, pc);
            // R3 strobe timing, R2 start source
            chk(result_vld == 1'b1, kind == 0 ? "R3 strobe" : "R2 trigger start",
                int'(result_vld), 1);
            // R5 R4 R8 interval
            chk(int'(interval_q) == iv, pc == 0 ? "R7 interval zero" : "R5 interval",
                int'(interval_q), iv);
            // R6 R4 R8 count
            chk(int'(pulses_q) == pc, pc == 0 ? "R7 count zero" : "R6 count",
                int'(pulses_q), pc);
            last_iv = iv; last_pc = pc;
         end else if (result_vld) begin
            stray++;
         end
         sig_in = sig_at(g, per, ph);
      end
      chk(stray == 0, "R3 no stray strobe", stray, 0);
   endtask

   initial begin
      automatic int pers[8] = '{2, 3, 4, 5, 7, 9, 17, 40};
      int stray;
      int hold_iv;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(interval_q == '0, "R1 interval", int'(interval_q), 0);
      chk(pulses_q == '0, "R1 count", int'(pulses_q), 0);
      chk(result_vld == 1'b0, "R1 strobe", int'(result_vld), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R8 edges before start ignored: toggle while disabled, then start clean
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         sig_in = k[0];
      end

      // Sweep periods, phases and polarities (R4 R5 R6 R7 R8)
      for (int f = 0; f < 2; f++)
         for (int pi = 0; pi < 8; pi++)
            for (int ph = 0; ph < 4; ph++)
               run_cfg(16, 16, pers[pi], ph, f[0], 3, 0);

      // R3 window length below minimum treated as 2
      run_cfg(1, 2, 3, 0, 1'b0, 4, 0);
      run_cfg(0, 2, 2, 1, 1'b1, 4, 0);
      run_cfg(5, 5, 2, 0, 1'b0, 3, 0);

      // R2 trigger mode waits with no trigger
      go_idle();
      hold_iv = int'(interval_q);
      @(negedge clk);
      start_mode = 1'b1; enable = 1'b1; win_len = 8'd4;
      stray = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (result_vld) stray++;
         sig_in = ((k % 3) == 0);
      end
      chk(stray == 0, "R2 no window without trigger", stray, 0);
      chk(int'(interval_q) == hold_iv, "R2 results untouched", int'(interval_q), hold_iv);

      // R2 each trigger source
      run_cfg(12, 12, 3, 1, 1'b0, 2, 1);
      run_cfg(12, 12, 4, 0, 1'b1, 2, 2);
      run_cfg(12, 12, 2, 0, 1'b0, 2, 3);

      // R9 drop enable in mid-window, results hold
      run_cfg(16, 16, 3, 0, 1'b0, 1, 0);
      repeat (5) @(negedge clk);
      enable = 1'b0;
      stray = 0;
      for (int k = 0; k < 50; k++) begin
         @(negedge clk);
         if (result_vld) stray++;
         sig_in = ((k % 2) == 0);
      end
      chk(stray == 0, "R9 no strobe while disabled", stray, 0);
      chk(int'(interval_q) == last_iv, "R9 interval held", int'(interval_q), last_iv);
      chk(int'(pulses_q) == last_pc, "R9 count held", int'(pulses_q), last_pc);
      chk(last_pc == 5, "R10 published count", last_pc, 5);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule